// File: doc/BRIEF.md
# Single-Writeback Commit Arbiter

This block sits at the retirement end of a multi-unit execution pipeline. Every execution unit (no-op, integer, load/store, control-register, floating-point and graphics-style units, six by default) presents one finished result per cycle. Each result carries a valid bit, a flag that says whether it must write the register file, a per-thread activity mask, the destination register and the warp that owns it. The register file has a single write port. The arbiter therefore lets at most one register-writing result retire in a cycle. Results that write nothing all retire together in that same cycle.

For every result it retires, the arbiter pulses that unit's dequeue line. In the same cycle it raises a scoreboard release strobe that carries the destination register and warp number. It also keeps three 64-bit statistics: instructions issued, instructions committed and thread-instructions retired. The pop and release outputs are combinational from the unit inputs. The statistics are registered and change on the following clock edge. A `running` output shows that some issued work has not yet retired.

Top module: `commit_arbiter`

## Requirements
- R1: Units are scanned from index 0 upward. Among the valid units whose writeback flag is 1, only the lowest-indexed one is granted, and `wb_grant` is one-hot on that unit.
- R2: At most one unit with the writeback flag set is popped in a cycle. Every other valid writeback unit is held, with its pop bit at 0, and `wb_grant` is zero when no valid unit asks for writeback.
- R3: Every valid unit whose writeback flag is 0 is popped in the same cycle, whether or not a writeback was granted.
- R4: A unit whose valid bit is 0 is never popped, whatever its writeback flag, mask, register or warp inputs hold.
- R5: For each unit, `rel_valid` equals its pop bit in the same cycle. `rel_rd` and `rel_wid` carry that unit's destination register and warp id when released and are 0 otherwise.
- R6: `commit_count` increases, one clock edge later, by the number of pop bits set in the current cycle.
- R7: `thread_count` increases, one clock edge later, by the total number of set bits in the thread masks of the popped units. Masks of held or invalid units add nothing.
- R8: `issue_count` increases by 1 on each clock edge where `issue_valid` is 1. Under legal stimulus, `commit_count` never exceeds `issue_count`.
- R9: `running` is 1 exactly when `commit_count` differs from `issue_count`.
- R10: An active-low asynchronous reset clears all three counters to 0 and drives `running` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_valid | input | 1 | One instruction issued this cycle |
| unit_valid | input | NUM_UNITS | Unit has a finished result |
| unit_wb | input | NUM_UNITS | Result needs a register-file write |
| unit_tmask | input | NUM_UNITS x NUM_THREADS | Active-thread mask of each result |
| unit_rd | input | NUM_UNITS x RD_W | Destination register of each result |
| unit_wid | input | NUM_UNITS x WID_W | Warp id of each result |
| unit_pop | output | NUM_UNITS | Dequeue strobe per unit |
| rel_valid | output | NUM_UNITS | Scoreboard release strobe per unit |
| rel_rd | output | NUM_UNITS x RD_W | Register being released, 0 when idle |
| rel_wid | output | NUM_UNITS x WID_W | Warp of the release, 0 when idle |
| wb_grant | output | NUM_UNITS | One-hot register-write grant |
| issue_count | output | 64 | Instructions issued since reset |
| commit_count | output | 64 | Instructions committed since reset |
| thread_count | output | 64 | Thread-instructions retired since reset |
| running | output | 1 | Issued work not yet retired |

## Verification
On every cycle the assertions check the following: the write-port limit, the lowest-index grant, that no non-writing result is held, that no invalid unit is popped, that the commit counter steps by the pop count, and that commits stay at or below issues. Correct register and warp values on the release lines depend on data, as does the thread-mask total. These and the reset values are shown only by the bench's scenarios. The bench runs directed collision patterns, a long stretch of random unit traffic limited to outstanding work, and a drain to idle, and compares every cycle against its own model.

// File: rtl/commit_pkg.sv
package commit_pkg;

  localparam int CNT_W = 64;

  // Number of set bits in a vector of up to 32 bits.
  function automatic int unsigned ones32(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) begin
      n = n + {31'd0, v[i]};
    end
    return n;
  endfunction

  // Isolate the least significant set bit.
  function automatic logic [31:0] lowest_one32(input logic [31:0] v);
    return v & (~v + 32'd1);
  endfunction

endpackage

// File: rtl/commit_select.sv
module commit_select
  import commit_pkg::*;
#(
  parameter int NUM_UNITS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_UNITS-1:0] unit_valid,
  input  logic [NUM_UNITS-1:0] unit_wb,
  output logic [NUM_UNITS-1:0] unit_pop,
  output logic [NUM_UNITS-1:0] wb_grant
);

  logic                 taken;
  logic [NUM_UNITS-1:0] wb_req;

  assign wb_req = unit_valid & unit_wb;

  always_comb begin
    taken    = 1'b0;
    unit_pop = '0;
    wb_grant = '0;
    for (int i = 0; i < NUM_UNITS; i++) begin
      if (unit_valid[i]) begin
        if (!unit_wb[i]) begin
          unit_pop[i] = 1'b1;
        end else if (!taken) begin
          unit_pop[i] = 1'b1;
          wb_grant[i] = 1'b1;
          taken       = 1'b1;
        end
      end
    end
  end

  AST_FIRST_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (|wb_req) |-> (wb_grant == NUM_UNITS'(lowest_one32(32'(wb_req))))); // R1

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(unit_pop & unit_wb) <= 1); // R2

  AST_NOWB_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    ((unit_valid & ~unit_wb) & ~unit_pop) == '0); // R3

  AST_NO_IDLE_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_pop & ~unit_valid) == '0); // R4

endmodule

// File: rtl/commit_tally.sv
module commit_tally
  import commit_pkg::*;
#(
  parameter int NUM_UNITS   = 6,
  parameter int NUM_THREADS = 4,
  parameter int POP_W       = $clog2(NUM_UNITS + 1),
  parameter int SUM_W       = $clog2(NUM_UNITS * NUM_THREADS + 1)
) (
  input  logic [NUM_UNITS-1:0]                  unit_pop,
  input  logic [NUM_UNITS-1:0][NUM_THREADS-1:0] unit_tmask,
  output logic [POP_W-1:0]                      pop_cnt,
  output logic [SUM_W-1:0]                      thread_sum
);

  localparam int ONE_W = $clog2(NUM_THREADS + 1);

  logic [NUM_UNITS-1:0][ONE_W-1:0] unit_ones;

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
    assign unit_ones[g] = unit_pop[g] ? ONE_W'(ones32(32'(unit_tmask[g]))) : '0;
  end

  assign pop_cnt = POP_W'(ones32(32'(unit_pop)));

  always_comb begin
    thread_sum = '0;
    for (int i = 0; i < NUM_UNITS; i++) begin
      thread_sum = thread_sum + SUM_W'(unit_ones[i]);
    end
  end

endmodule

// File: rtl/commit_counters.sv
module commit_counters
  import commit_pkg::*;
#(
  parameter int POP_W = 3,
  parameter int SUM_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_valid,
  input  logic [POP_W-1:0] pop_cnt,
  input  logic [SUM_W-1:0] thread_sum,
  output logic [CNT_W-1:0] issue_count,
  output logic [CNT_W-1:0] commit_count,
  output logic [CNT_W-1:0] thread_count,
  output logic             running
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issue_count  <= '0;
      commit_count <= '0;
      thread_count <= '0;
    end else begin
      issue_count  <= issue_count + CNT_W'(issue_valid);
      commit_count <= commit_count + CNT_W'(pop_cnt);
      thread_count <= thread_count + CNT_W'(thread_sum);
    end
  end

  assign running = (commit_count != issue_count);

  AST_COMMIT_LE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_count <= issue_count); // R8

endmodule

// File: rtl/commit_arbiter.sv
module commit_arbiter
  import commit_pkg::*;
#(
  parameter int NUM_UNITS   = 6,
  parameter int NUM_THREADS = 4,
  parameter int RD_W        = 5,
  parameter int WID_W       = 2
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  issue_valid,
  input  logic [NUM_UNITS-1:0]                  unit_valid,
  input  logic [NUM_UNITS-1:0]                  unit_wb,
  input  logic [NUM_UNITS-1:0][NUM_THREADS-1:0] unit_tmask,
  input  logic [NUM_UNITS-1:0][RD_W-1:0]        unit_rd,
  input  logic [NUM_UNITS-1:0][WID_W-1:0]       unit_wid,
  output logic [NUM_UNITS-1:0]                  unit_pop,
  output logic [NUM_UNITS-1:0]                  rel_valid,
  output logic [NUM_UNITS-1:0][RD_W-1:0]        rel_rd,
  output logic [NUM_UNITS-1:0][WID_W-1:0]       rel_wid,
  output logic [NUM_UNITS-1:0]                  wb_grant,
  output logic [63:0]                           issue_count,
  output logic [63:0]                           commit_count,
  output logic [63:0]                           thread_count,
  output logic                                  running
);

  localparam int POP_W = $clog2(NUM_UNITS + 1);
  localparam int SUM_W = $clog2(NUM_UNITS * NUM_THREADS + 1);

  logic [POP_W-1:0] pop_cnt;
  logic [SUM_W-1:0] thread_sum;

  commit_select #(.NUM_UNITS(NUM_UNITS)) i_select (
    .clk        (clk),
    .rst_n      (rst_n),
    .unit_valid (unit_valid),
    .unit_wb    (unit_wb),
    .unit_pop   (unit_pop),
    .wb_grant   (wb_grant)
  );

  commit_tally #(
    .NUM_UNITS   (NUM_UNITS),
    .NUM_THREADS (NUM_THREADS),
    .POP_W       (POP_W),
    .SUM_W       (SUM_W)
  ) i_tally (
    .unit_pop   (unit_pop),
    .unit_tmask (unit_tmask),
    .pop_cnt    (pop_cnt),
    .thread_sum (thread_sum)
  );

  commit_counters #(.POP_W(POP_W), .SUM_W(SUM_W)) i_counters (
    .clk          (clk),
    .rst_n        (rst_n),
    .issue_valid  (issue_valid),
    .pop_cnt      (pop_cnt),
    .thread_sum   (thread_sum),
    .issue_count  (issue_count),
    .commit_count (commit_count),
    .thread_count (thread_count),
    .running      (running)
  );

  // Scoreboard release routing: same cycle as the pop.
  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_rel
    assign rel_valid[g] = unit_pop[g];
    assign rel_rd[g]    = unit_pop[g] ? unit_rd[g]  : '0;
    assign rel_wid[g]   = unit_pop[g] ? unit_wid[g] : '0;
  end

  AST_GRANT_IS_WB_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_pop & unit_wb) == wb_grant); // R2

  AST_COMMIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (commit_count - $past(commit_count)) == 64'($countones($past(unit_pop)))); // R6

endmodule

// File: tb/test_commit_arbiter.sv
`timescale 1ns/1ps
module test_commit_arbiter;

  localparam int N  = 6;
  localparam int T  = 4;
  localparam int RW = 5;
  localparam int WW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue_valid = 1'b0;
  logic [N-1:0] unit_valid = '0;
  logic [N-1:0] unit_wb = '0;
  logic [N-1:0][T-1:0] unit_tmask = '0;
  logic [N-1:0][RW-1:0] unit_rd = '0;
  logic [N-1:0][WW-1:0] unit_wid = '0;
  logic [N-1:0] unit_pop, rel_valid, wb_grant;
  logic [N-1:0][RW-1:0] rel_rd;
  logic [N-1:0][WW-1:0] rel_wid;
  logic [63:0] issue_count, commit_count, thread_count;
  logic running;

  always #2.5 clk = ~clk;

  commit_arbiter #(.NUM_UNITS(N), .NUM_THREADS(T), .RD_W(RW), .WID_W(WW)) i_commit_arbiter (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
    .unit_valid(unit_valid), .unit_wb(unit_wb), .unit_tmask(unit_tmask),
    .unit_rd(unit_rd), .unit_wid(unit_wid), .unit_pop(unit_pop),
    .rel_valid(rel_valid), .rel_rd(rel_rd), .rel_wid(rel_wid),
    .wb_grant(wb_grant), .issue_count(issue_count), .commit_count(commit_count),
    .thread_count(thread_count), .running(running)
  );

  typedef struct {
    logic [N-1:0]         pop;
    logic [N-1:0]         grant;
    logic [N-1:0][RW-1:0] rd;
    logic [N-1:0][WW-1:0] wid;
    logic [63:0]          iss;
    logic [63:0]          com;
    logic [63:0]          thr;
    logic                 run;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [63:0] m_iss = 0, m_com = 0, m_thr = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Reference: walk units upward, first writer wins, all non-writers retire.
  function automatic logic [N-1:0] model_pop(input logic [N-1:0] v, input logic [N-1:0] w,
                                             output logic [N-1:0] g);
    logic [N-1:0] p;
    bit used;
    p = '0; g = '0; used = 0;
    for (int i = 0; i < N; i++) begin
      if (v[i] && !w[i]) p[i] = 1'b1;
      if (v[i] && w[i] && !used) begin p[i] = 1'b1; g[i] = 1'b1; used = 1; end
    end
    return p;
  endfunction

  function automatic int count_bits(input logic [N-1:0] p);
    int c = 0;
    for (int i = 0; i < N; i++) if (p[i]) c++;
    return c;
  endfunction

  task automatic drive(input logic iss, input logic [N-1:0] v, input logic [N-1:0] w,
                       input logic [N-1:0][T-1:0] tm, input logic [N-1:0][RW-1:0] rd,
                       input logic [N-1:0][WW-1:0] wid);
    exp_t e;
    logic [N-1:0] g;
    @(negedge clk);
    issue_valid = iss; unit_valid = v; unit_wb = w;
    unit_tmask = tm; unit_rd = rd; unit_wid = wid;
    e.pop = model_pop(v, w, g);
    e.grant = g;
    for (int i = 0; i < N; i++) begin
      e.rd[i]  = e.pop[i] ? rd[i]  : '0;
      e.wid[i] = e.pop[i] ? wid[i] : '0;
      if (e.pop[i]) for (int j = 0; j < T; j++) m_thr = m_thr + {63'd0, tm[i][j]};
    end
    m_iss = m_iss + {63'd0, iss};
    m_com = m_com + 64'(count_bits(e.pop));
    e.iss = m_iss; e.com = m_com; e.thr = m_thr; e.run = (m_iss != m_com);
    exp_q.push_back(e);
  endtask

  // Monitor: just after each edge, combinational outputs still reflect the
  // driven cycle and the counters hold that cycle's update.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R1 R2 R3 R4 pop", 64'(unit_pop), 64'(e.pop));
        chk("R1 R2 grant", 64'(wb_grant), 64'(e.grant));
        chk("R5 release valid", 64'(rel_valid), 64'(e.pop));
        chk("R5 release rd", 64'(rel_rd), 64'(e.rd));
        chk("R5 release wid", 64'(rel_wid), 64'(e.wid));
        chk("R6 commit count", commit_count, e.com);
        chk("R7 thread count", thread_count, e.thr);
        chk("R8 issue count", issue_count, e.iss);
        chk("R9 running", 64'(running), 64'(e.run));
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0][T-1:0] tm;
    logic [N-1:0][RW-1:0] rd;
    logic [N-1:0][WW-1:0] wd;
    logic [N-1:0] v, w, g, p;
    void'($urandom(17));
    for (int i = 0; i < N; i++) begin
      tm[i] = T'(i + 5); rd[i] = RW'(3 * i + 1); wd[i] = WW'(i);
    end
    repeat (3) @(negedge clk);
    #1;
    // R10: reset values
    chk("R10 reset issue", issue_count, 64'd0);
    chk("R10 reset commit", commit_count, 64'd0);
    chk("R10 reset thread", thread_count, 64'd0);
    chk("R10 reset running", 64'(running), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // Issue a pool of outstanding work.
    repeat (40) drive(1'b1, '0, '0, tm, rd, wd);
    // Directed collision patterns.
    drive(1'b0, 6'b111111, 6'b111111, tm, rd, wd);  // R1: only unit 0
    drive(1'b0, 6'b111111, 6'b010100, tm, rd, wd);  // R2: unit 4 held
    drive(1'b0, 6'b101010, 6'b111111, tm, rd, wd);  // R4: invalid writers ignored
    drive(1'b0, 6'b111111, 6'b000000, tm, rd, wd);  // R3: all retire
    drive(1'b0, 6'b100000, 6'b111111, tm, rd, wd);  // R1: unit 5 only writer
    drive(1'b0, 6'b000000, 6'b111111, tm, rd, wd);  // R4: nothing valid
    drive(1'b1, 6'b011000, 6'b011000, tm, rd, wd);  // R2: unit 4 held again

    // Random traffic limited to outstanding work.
    for (int k = 0; k < 400; k++) begin
      logic iss;
      for (int i = 0; i < N; i++) begin
        tm[i] = T'($urandom); rd[i] = RW'($urandom); wd[i] = WW'($urandom);
      end
      v = N'($urandom); w = N'($urandom); iss = 1'($urandom);
      p = model_pop(v, w, g);
      if (64'(count_bits(p)) > (m_iss - m_com)) v = '0;
      drive(iss, v, w, tm, rd, wd);
    end

    // Drain everything outstanding with non-writing results.
    while (m_iss != m_com) begin
      logic [63:0] rem;
      rem = m_iss - m_com;
      v = (rem >= 64'(N)) ? '1 : N'((64'd1 << rem) - 64'd1);
      drive(1'b0, v, '0, tm, rd, wd);
    end
    drive(1'b0, '0, '0, tm, rd, wd);
    repeat (3) @(negedge clk);
    chk("R9 idle after drain", 64'(running), 64'd0);

    // R10: asynchronous reset mid-run clears counters.
    drive(1'b1, '0, '0, tm, rd, wd);
    drive(1'b1, '0, '0, tm, rd, wd);
    @(negedge clk);
    issue_valid = 1'b0;
    #1;
    rst_n = 1'b0;
    #0.5;
    chk("R10 async issue clear", issue_count, 64'd0);
    chk("R10 async commit clear", commit_count, 64'd0);
    chk("R10 async thread clear", thread_count, 64'd0);
    chk("R10 async running low", 64'(running), 64'd0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule